// File: doc/BRIEF.md
# Blinking Single-Colour Cursor Overlay

This block sits at the end of a display pipeline and places a small hardware cursor over the already composited pixel stream. Each cycle the raster timing logic presents the screen coordinate of the current pixel together with its RGB value. The block compares the coordinate with a programmed rectangle. Where the coordinate falls inside the rectangle and the matching bit of the cursor bitmap is set, the pixel is replaced by one programmed colour. Every other pixel passes through unchanged. The cursor always wins over the underlying picture and is never blended with it.

The bitmap holds one bit per cursor pixel in a dedicated internal memory. That memory is loaded through a simple write port. The memory dimensions set the largest cursor the block can show. Visibility follows a frame-counting blink timer that is advanced by a one-cycle pulse at each vertical sync. The timer shows the cursor for a programmed number of frames and then hides it for a programmed number of frames. An off count of zero gives a cursor that never blinks.

Top module: `cursor_overlay`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `pix_out` is 0.
- R2: A pixel whose coordinate lies outside the cursor rectangle appears unchanged on `pix_out` exactly one clock after it is presented.
- R3: Where the coordinate lies inside the rectangle, the cursor is enabled and visible, and the bitmap bit is 1, `pix_out` shows `cur_rgb` one clock later, whatever the incoming pixel is.
- R4: Inside the rectangle, a bitmap bit of 0 passes the incoming pixel unchanged.
- R5: While `cur_en` is low, every pixel passes unchanged, including those that cover set bitmap bits.
- R6: The rectangle covers columns `pos_x` to `pos_x+W-1` and rows `pos_y` to `pos_y+H-1`. Here W is `cur_w` and H is `cur_h`, each clamped to the bitmap limits (MAX_W, MAX_H). A width or height of 0 shows no cursor.
- R7: The bit for cursor column c and row r is written at bitmap address r*MAX_W + c through `bm_we`/`bm_addr`/`bm_bit`, where c = x - `pos_x` and r = y - `pos_y`.
- R8: With `blink_off` non-zero, the cursor is visible for `blink_on` frame pulses, then hidden for `blink_off` frame pulses, and the pattern repeats. A count of 0 behaves as 1.
- R9: With `blink_off` equal to 0, the cursor stays visible regardless of frame pulses.
- R10: Lowering `cur_en` restarts the blink sequence, so that on re-enable the cursor is visible at the start of its on period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_en | input | 1 | Cursor enable |
| cur_w | input | COORD_W | Cursor width in pixels |
| cur_h | input | COORD_W | Cursor height in pixels |
| pos_x | input | COORD_W | Screen column of the cursor's top-left pixel |
| pos_y | input | COORD_W | Screen row of the cursor's top-left pixel |
| cur_rgb | input | 24 | Cursor colour, RGB888 |
| blink_on | input | BLINK_W | Visible period in frames |
| blink_off | input | BLINK_W | Hidden period in frames; 0 means steady |
| frame_tick | input | 1 | One-cycle pulse per vertical sync |
| bm_we | input | 1 | Bitmap write strobe |
| bm_addr | input | ADDR_W | Bitmap write address (row*MAX_W + column) |
| bm_bit | input | 1 | Bitmap write data |
| pix_x | input | COORD_W | Column of the incoming pixel |
| pix_y | input | COORD_W | Row of the incoming pixel |
| pix_in | input | 24 | Incoming composited pixel |
| pix_out | output | 24 | Final pixel, one clock after input |

## Verification
A fault in the rectangle comparison shows up as a cursor pixel one column or row off the intended edge. It appears on `pix_out` in the cycle after that coordinate is presented, so the probes sit on and just beyond each edge, and also at the clamped width limit. A wrong blink state or count does not appear until the next frame pulse. For that reason the bench probes a set cursor pixel after every pulse of an on/off sequence, and again after disable and re-enable. A wrong bitmap address gives a cursor colour where a pass-through is expected, or the reverse. It is caught by a checkerboard pattern and by a lone bit in the last column.

// File: rtl/cur_pkg.sv
`timescale 1ns/1ps
package cur_pkg;
  localparam int RGB_W = 24;

  typedef enum logic {
    BLK_SHOW = 1'b0,
    BLK_HIDE = 1'b1
  } blink_st_e;
endpackage

// File: rtl/cur_bitmap_ram.sv
`timescale 1ns/1ps
module cur_bitmap_ram #(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              wbit,
  input  logic [ADDR_W-1:0] raddr,
  output logic              rbit
);
  // simple dual-port, registered read: maps onto a block RAM
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wbit;
  end

  always_ff @(posedge clk) begin
    rbit <= mem[raddr];
  end
endmodule

// File: rtl/cur_hit_calc.sv
`timescale 1ns/1ps
module cur_hit_calc #(
  parameter int COORD_W = 11,
  parameter int MAX_W   = 32,
  parameter int MAX_H   = 32,
  parameter int ADDR_W  = $clog2(MAX_W*MAX_H)
) (
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [COORD_W-1:0] pos_x,
  input  logic [COORD_W-1:0] pos_y,
  input  logic [COORD_W-1:0] cur_w,
  input  logic [COORD_W-1:0] cur_h,
  output logic               in_rect,
  output logic [ADDR_W-1:0]  rd_addr
);
  localparam logic [COORD_W-1:0] LIM_W = COORD_W'(MAX_W);
  localparam logic [COORD_W-1:0] LIM_H = COORD_W'(MAX_H);

  logic [COORD_W-1:0] w_eff, h_eff, dx, dy;
  logic               in_x, in_y;

  always_comb begin
    w_eff   = (cur_w > LIM_W) ? LIM_W : cur_w;
    h_eff   = (cur_h > LIM_H) ? LIM_H : cur_h;
    dx      = pix_x - pos_x;
    dy      = pix_y - pos_y;
    in_x    = (pix_x >= pos_x) && (dx < w_eff);
    in_y    = (pix_y >= pos_y) && (dy < h_eff);
    in_rect = in_x && in_y;
    rd_addr = ADDR_W'(dy) * ADDR_W'(MAX_W) + ADDR_W'(dx);
  end
endmodule

// File: rtl/cur_blink_timer.sv
`timescale 1ns/1ps
module cur_blink_timer
  import cur_pkg::*;
#(
  parameter int BLINK_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               tick,
  input  logic [BLINK_W-1:0] on_time,
  input  logic [BLINK_W-1:0] off_time,
  output logic               visible
);
  blink_st_e          state;
  logic [BLINK_W-1:0] cnt;
  logic [BLINK_W:0]   cnt_nx;
  logic               steady;

  assign cnt_nx  = {1'b0, cnt} + 1'b1;
  assign steady  = (off_time == '0);
  assign visible = (state == BLK_SHOW) || steady;

  always_ff @(posedge clk) begin
    if (rst || !en || steady) begin
      state <= BLK_SHOW;
      cnt   <= '0;
    end else if (tick) begin
      if (state == BLK_SHOW) begin
        if (cnt_nx >= {1'b0, on_time}) begin
          state <= BLK_HIDE;
          cnt   <= '0;
        end else begin
          cnt <= cnt_nx[BLINK_W-1:0];
        end
      end else begin
        if (cnt_nx >= {1'b0, off_time}) begin
          state <= BLK_SHOW;
          cnt   <= '0;
        end else begin
          cnt <= cnt_nx[BLINK_W-1:0];
        end
      end
    end
  end

  // R9 / R10: steady or disabled forces the start of the on period
  p_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (!en || steady) |=> (state == BLK_SHOW && cnt == '0));

  // R8: phase only moves on a frame pulse
  p_tick_only_r8: assert property (@(posedge clk) disable iff (rst)
    (en && !steady && !tick) |=> ($stable(state) && $stable(cnt)));
endmodule

// File: rtl/cursor_overlay.sv
`timescale 1ns/1ps
module cursor_overlay
  import cur_pkg::*;
#(
  parameter int COORD_W = 11,
  parameter int MAX_W   = 32,
  parameter int MAX_H   = 32,
  parameter int BLINK_W = 8,
  localparam int DEPTH  = MAX_W * MAX_H,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cur_en,
  input  logic [COORD_W-1:0] cur_w,
  input  logic [COORD_W-1:0] cur_h,
  input  logic [COORD_W-1:0] pos_x,
  input  logic [COORD_W-1:0] pos_y,
  input  logic [RGB_W-1:0]   cur_rgb,
  input  logic [BLINK_W-1:0] blink_on,
  input  logic [BLINK_W-1:0] blink_off,
  input  logic               frame_tick,
  input  logic               bm_we,
  input  logic [ADDR_W-1:0]  bm_addr,
  input  logic               bm_bit,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [RGB_W-1:0]   pix_in,
  output logic [RGB_W-1:0]   pix_out
);
  logic              in_rect, vis, rd_bit;
  logic [ADDR_W-1:0] rd_addr;

  logic              stg_hit;
  logic [RGB_W-1:0]  stg_pix, stg_col;

  cur_hit_calc #(
    .COORD_W(COORD_W), .MAX_W(MAX_W), .MAX_H(MAX_H), .ADDR_W(ADDR_W)
  ) u_hit (
    .pix_x(pix_x), .pix_y(pix_y), .pos_x(pos_x), .pos_y(pos_y),
    .cur_w(cur_w), .cur_h(cur_h), .in_rect(in_rect), .rd_addr(rd_addr)
  );

  cur_blink_timer #(.BLINK_W(BLINK_W)) u_blink (
    .clk(clk), .rst(rst), .en(cur_en), .tick(frame_tick),
    .on_time(blink_on), .off_time(blink_off), .visible(vis)
  );

  cur_bitmap_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(bm_we), .waddr(bm_addr), .wbit(bm_bit),
    .raddr(rd_addr), .rbit(rd_bit)
  );

  // stage aligned with the registered bitmap read
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_hit <= 1'b0;
      stg_pix <= '0;
      stg_col <= '0;
    end else begin
      stg_hit <= cur_en && vis && in_rect;
      stg_pix <= pix_in;
      stg_col <= cur_rgb;
    end
  end

  assign pix_out = (stg_hit && rd_bit) ? stg_col : stg_pix;

  // R5: disabled cursor is transparent with one cycle of latency
  p_pass_disabled_r5: assert property (@(posedge clk) disable iff (rst)
    !cur_en |=> (pix_out == $past(pix_in)));

  // R2: left of or above the rectangle always passes through
  p_pass_outside_r2: assert property (@(posedge clk) disable iff (rst)
    ((pix_x < pos_x) || (pix_y < pos_y)) |=> (pix_out == $past(pix_in)));

  // R6: zero-size rectangle never draws
  p_zero_size_r6: assert property (@(posedge clk) disable iff (rst)
    ((cur_w == '0) || (cur_h == '0)) |=> (pix_out == $past(pix_in)));

  // R1: output cleared in the cycle after reset
  p_reset_out_r1: assert property (@(posedge clk)
    rst |=> (pix_out == '0));
endmodule

// File: tb/sim_cursor_overlay.sv
`timescale 1ns/1ps
module sim_cursor_overlay;
  localparam int CW = 11;
  localparam int MW = 32;
  localparam int MH = 32;
  localparam int BW = 8;
  localparam int AW = $clog2(MW*MH);
  localparam logic [23:0] COL = 24'hFF00AA;
  localparam int PX = 10;
  localparam int PY = 5;

  // vector table: x, y, incoming pixel, expected output (R2/R3/R4/R7)
  localparam int NV = 10;
  localparam int VX [NV] = '{ 9, 10, 11, 13, 14, 12, 12, 10, 11, 13};
  localparam int VY [NV] = '{ 5,  5,  5,  6,  6,  7,  8,  4,  6,  7};
  localparam logic [23:0] VP [NV] = '{24'h111111, 24'h222222, 24'h333333,
    24'h444444, 24'h555555, 24'h666666, 24'h777777, 24'h888888,
    24'h999999, 24'hAAAAAA};
  localparam logic [23:0] VE [NV] = '{24'h111111, COL, 24'h333333,
    COL, 24'h555555, COL, 24'h777777, 24'h888888, COL, 24'hAAAAAA};

  logic clk = 0, rst = 1;
  logic cur_en = 0, frame_tick = 0, bm_we = 0, bm_bit = 0;
  logic [CW-1:0] cur_w = 4, cur_h = 3, pos_x = PX, pos_y = PY;
  logic [CW-1:0] pix_x = 0, pix_y = 0;
  logic [23:0] cur_rgb = COL, pix_in = 0, pix_out;
  logic [BW-1:0] blink_on = 2, blink_off = 0;
  logic [AW-1:0] bm_addr = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cursor_overlay #(.COORD_W(CW), .MAX_W(MW), .MAX_H(MH), .BLINK_W(BW)) u0 (
    .clk(clk), .rst(rst), .cur_en(cur_en), .cur_w(cur_w), .cur_h(cur_h),
    .pos_x(pos_x), .pos_y(pos_y), .cur_rgb(cur_rgb), .blink_on(blink_on),
    .blink_off(blink_off), .frame_tick(frame_tick), .bm_we(bm_we),
    .bm_addr(bm_addr), .bm_bit(bm_bit), .pix_x(pix_x), .pix_y(pix_y),
    .pix_in(pix_in), .pix_out(pix_out)
  );

  task automatic chk(string req, logic [23:0] got, logic [23:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic probe(int x, int y, logic [23:0] p, string req, logic [23:0] exp);
    @(negedge clk);
    pix_x = CW'(x); pix_y = CW'(y); pix_in = p;
    @(posedge clk); #1;
    chk(req, pix_out, exp);
  endtask

  task automatic wr_bit(int r, int c, logic b);
    @(negedge clk);
    bm_we = 1; bm_addr = AW'(r*MW + c); bm_bit = b;
    @(negedge clk);
    bm_we = 0;
  endtask

  task automatic tick();
    @(negedge clk); frame_tick = 1;
    @(negedge clk); frame_tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    pix_in = 24'hABCDEF;
    repeat (3) @(posedge clk); #1;
    chk("R1 during reset", pix_out, 24'h0);
    @(negedge clk); rst = 0;
    #1 chk("R1 after reset", pix_out, 24'h0);

    // checkerboard over 4x3 (R7 addressing)
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 4; c++)
        wr_bit(r, c, ((r + c) % 2) == 0);
    wr_bit(0, 31, 1'b1);
    wr_bit(0, 32 - 1 + 0, 1'b1);

    @(negedge clk); cur_en = 1;
    for (int i = 0; i < NV; i++)
      probe(VX[i], VY[i], VP[i], "R2/R3/R4/R7 table", VE[i]);

    // R5 disabled
    @(negedge clk); cur_en = 0;
    probe(PX, PY, 24'h123456, "R5 disabled", 24'h123456);
    @(negedge clk); cur_en = 1;

    // R6 zero width, clamp
    @(negedge clk); cur_w = 0;
    probe(PX, PY, 24'h0F0F0F, "R6 zero width", 24'h0F0F0F);
    @(negedge clk); cur_w = 40;
    probe(PX + 31, PY, 24'h010203, "R6 last clamped column", COL);
    probe(PX + 32, PY, 24'h040506, "R6 beyond clamp", 24'h040506);
    @(negedge clk); cur_w = 4;

    // R9 steady with off=0
    @(negedge clk); blink_off = 0;
    for (int k = 0; k < 3; k++) tick();
    probe(PX, PY, 24'h202020, "R9 steady", COL);

    // R8 blink on=2 off=1
    @(negedge clk); cur_en = 0; blink_on = 2; blink_off = 1;
    @(negedge clk); cur_en = 1;
    probe(PX, PY, 24'h303030, "R8 frame0 visible", COL);
    tick();
    probe(PX, PY, 24'h313131, "R8 frame1 visible", COL);
    tick();
    probe(PX, PY, 24'h323232, "R8 frame2 hidden", 24'h323232);
    tick();
    probe(PX, PY, 24'h333333, "R8 frame3 visible", COL);
    tick(); tick();
    probe(PX, PY, 24'h343434, "R8 hidden again", 24'h343434);

    // R10 restart on re-enable
    @(negedge clk); cur_en = 0;
    @(negedge clk); cur_en = 1;
    probe(PX, PY, 24'h353535, "R10 restart visible", COL);

    // R1 reset mid-stream
    @(negedge clk); rst = 1; pix_in = 24'h777777;
    @(posedge clk); #1;
    chk("R1 reset again", pix_out, 24'h0);
    @(negedge clk); rst = 0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule